// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs single clause-22 management transactions on an Ethernet PHY management bus. A request carries a direction (read or write), a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit value. The block builds the whole serial frame itself. It derives the management clock from the system clock, with each half-period lasting `HALF_PERIOD` system cycles. It drives the data line through a value and an enable for a tristate pad, and it samples the pad input for the turnaround and the read data.

Each frame is made of slots, and each slot is one management clock period. In every slot the clock is low for one half-period and high for the next. The master changes its data output only when the clock falls, so a target samples it on the rising edge. On reads, the master checks the first turnaround slot to find out whether a PHY answered. If no PHY answered, it clocks the bus for a fixed recovery interval and then reports an error. In that case it captures no data.

Top module: `mdio_master`

## Requirements
- R1: While no transaction is running, `busy` is 0, `mdc` is held at 1 and `mdio_oe` is 0. A request is taken only when `req_valid` is 1 and `busy` is 0. A request raised while `busy` is 1 has no effect: the running frame is unchanged and no second frame follows.
- R2: Every frame opens with 32 slots (PREAMBLE_LEN) in which `mdio_oe`=1 and `mdio_o`=1.
- R3: The next four slots carry the bits 0,1 and then the operation code: 1,0 for a read and 0,1 for a write.
- R4: Ten address slots follow. The first five carry the PHY address, most significant bit first. The last five carry the register address, most significant bit first.
- R5: Each low phase and each high phase of `mdc` inside a frame lasts exactly HALF_PERIOD system cycles. While `mdio_oe` stays 1, `mdio_o` changes only in the cycle where `mdc` falls.
- R6: In a write, slots 46 and 47 carry the turnaround 1,0 with the enable on. Slots 48 to 63 carry the write data, most significant bit first. Slot 64 has `mdio_oe`=0. The frame has 65 rising edges of `mdc` in total.
- R7: In a read, `mdio_oe` is 0 from slot 46 onward. `mdio_i` is sampled in the last system cycle of the high phase of slot 46. If it is 0, slots 47 to 62 are sampled the same way, most significant bit first, and two further slots follow, for 65 rising edges in total. At the end, `rd_data` holds the 16 sampled bits and `err` is 0.
- R8: If the turnaround sample in a read is 1, 32 recovery slots (RECOVER_LEN, slots 47 to 78) follow with `mdio_oe`=0, for 79 rising edges in total. The master then reports `err`=1 with `done`, and `rd_data` keeps its previous value.
- R9: `done` is a one-cycle pulse that follows the high phase of the last slot. `busy` goes to 1 in the cycle after a request is taken and goes back to 0 in the cycle of `done`. `err` is cleared when the next request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_read | input | 1 | 1 = read, 0 = write |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write value |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Data of the last successful read |
| err | output | 1 | Last read found no PHY |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data value toward the pad |
| mdio_oe | output | 1 | Pad output enable |
| mdio_i | input | 1 | Data sampled from the pad |

## Verification
The properties assume that `mdio_i` already comes from the system clock domain. They also assume that a target changes the line only after `mdc` falls, so the value sampled at the end of a high phase is settled. The bench PHY model obeys this: it updates its drive only on falling edges of `mdc`, and a pull-up supplies 1 whenever neither side drives. Request fields are held steady during the cycle in which a request is taken. The only request the bench raises during a transaction is a deliberate one, which the block must ignore.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;
  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] START_SEQ = 2'b01;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;
endpackage

// File: rtl/mdio_half_timer.sv
module mdio_half_timer #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == CW'(HALF - 1));
    cnt_d = cnt_q;
    if (clear) begin
      cnt_d = '0;
    end else if (run) begin
      cnt_d = tick ? '0 : cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mdio_rx_shift.sv
module mdio_rx_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb q_d = en ? {q[W-2:0], din} : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_PERIOD  = 4,
  parameter int PREAMBLE_LEN = 32,
  parameter int RECOVER_LEN  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_read,
  input  logic [ADDR_W-1:0] req_phy,
  input  logic [ADDR_W-1:0] req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              err,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  // slot map derived from the frame lengths
  localparam int HDR_W     = PREAMBLE_LEN + 4 + 2 * ADDR_W;
  localparam int WD_FIRST  = HDR_W + 2;
  localparam int RD_FIRST  = HDR_W + 1;
  localparam int RD_LAST   = HDR_W + DATA_W;
  localparam int LAST      = HDR_W + DATA_W + 2;
  localparam int MISS_LAST = HDR_W + RECOVER_LEN;
  localparam int MAX_SLOT  = (MISS_LAST > LAST) ? MISS_LAST : LAST;
  localparam int SW        = $clog2(MAX_SLOT + 1);

  localparam logic [SW-1:0] S_HDR       = SW'(HDR_W);
  localparam logic [SW-1:0] S_WD_FIRST  = SW'(WD_FIRST);
  localparam logic [SW-1:0] S_RD_FIRST  = SW'(RD_FIRST);
  localparam logic [SW-1:0] S_RD_LAST   = SW'(RD_LAST);
  localparam logic [SW-1:0] S_LAST      = SW'(LAST);
  localparam logic [SW-1:0] S_MISS_LAST = SW'(MISS_LAST);

  logic              busy_q, busy_d;
  logic              rd_q, rd_d;
  logic              miss_q, miss_d;
  phase_e            phase_q, phase_d;
  logic [SW-1:0]     slot_q, slot_d, nslot;
  logic [HDR_W-1:0]  hdr_q, hdr_d, hdr_sh;
  logic [DATA_W-1:0] wd_q, wd_d, wd_sh;
  logic [DATA_W-1:0] rdat_q, rdat_d, rx_q;
  logic              mdc_q, mdc_d, out_q, out_d, oe_q, oe_d;
  logic              done_q, done_d, err_q, err_d;
  logic              accept, tick, slot_end, at_last, ta_bad, rx_en;

  assign accept   = req_valid && !busy_q;
  assign slot_end = busy_q && tick && (phase_q == PH_HIGH);
  assign at_last  = miss_q ? (slot_q == S_MISS_LAST) : (slot_q == S_LAST);
  assign ta_bad   = slot_end && rd_q && (slot_q == S_HDR) && mdio_i;
  assign rx_en    = slot_end && rd_q && !miss_q &&
                    (slot_q >= S_RD_FIRST) && (slot_q <= S_RD_LAST);
  assign nslot    = slot_q + SW'(1);

  mdio_half_timer #(.HALF(HALF_PERIOD)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (accept),
    .run   (busy_q),
    .tick  (tick)
  );

  mdio_rx_shift #(.W(DATA_W)) u_rx (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (rx_en),
    .din   (mdio_i),
    .q     (rx_q)
  );

  always_comb begin
    busy_d  = busy_q;
    rd_d    = rd_q;
    miss_d  = miss_q;
    phase_d = phase_q;
    slot_d  = slot_q;
    hdr_d   = hdr_q;
    wd_d    = wd_q;
    rdat_d  = rdat_q;
    mdc_d   = mdc_q;
    out_d   = out_q;
    oe_d    = oe_q;
    err_d   = err_q;
    done_d  = 1'b0;
    hdr_sh  = {hdr_q[HDR_W-2:0], 1'b0};
    wd_sh   = (slot_q >= S_WD_FIRST) ? {wd_q[DATA_W-2:0], 1'b0} : wd_q;

    if (accept) begin
      busy_d  = 1'b1;
      rd_d    = req_read;
      miss_d  = 1'b0;
      err_d   = 1'b0;
      phase_d = PH_LOW;
      slot_d  = '0;
      hdr_d   = {{PREAMBLE_LEN{1'b1}}, START_SEQ,
                 req_read ? OPC_READ : OPC_WRITE, req_phy, req_reg};
      wd_d    = req_wdata;
      mdc_d   = 1'b0;
      oe_d    = 1'b1;
      out_d   = 1'b1;
    end else if (busy_q && tick) begin
      if (phase_q == PH_LOW) begin
        mdc_d   = 1'b1;
        phase_d = PH_HIGH;
      end else if (at_last) begin
        busy_d = 1'b0;
        oe_d   = 1'b0;
        done_d = 1'b1;
        err_d  = miss_q;
        if (rd_q && !miss_q) rdat_d = rx_q;
      end else begin
        slot_d  = nslot;
        phase_d = PH_LOW;
        mdc_d   = 1'b0;
        hdr_d   = hdr_sh;
        wd_d    = wd_sh;
        if (ta_bad) miss_d = 1'b1;
        if (nslot < S_HDR) begin
          oe_d  = 1'b1;
          out_d = hdr_sh[HDR_W-1];
        end else if (!rd_q && (nslot < S_WD_FIRST)) begin
          oe_d  = 1'b1;
          out_d = (nslot == S_HDR);
        end else if (!rd_q && (nslot < S_LAST)) begin
          oe_d  = 1'b1;
          out_d = wd_sh[DATA_W-1];
        end else begin
          oe_d  = 1'b0;
          out_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      rd_q    <= 1'b0;
      miss_q  <= 1'b0;
      phase_q <= PH_HIGH;
      slot_q  <= '0;
      hdr_q   <= '0;
      wd_q    <= '0;
      rdat_q  <= '0;
      mdc_q   <= 1'b1;
      out_q   <= 1'b1;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      rd_q    <= rd_d;
      miss_q  <= miss_d;
      phase_q <= phase_d;
      slot_q  <= slot_d;
      hdr_q   <= hdr_d;
      wd_q    <= wd_d;
      rdat_q  <= rdat_d;
      mdc_q   <= mdc_d;
      out_q   <= out_d;
      oe_q    <= oe_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign rd_data = rdat_q;
  assign err     = err_q;
  assign mdc     = mdc_q;
  assign mdio_o  = out_q;
  assign mdio_oe = oe_q;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_read,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic [15:0] rd_data,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  logic last_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   last_rd <= 1'b0;
    else if (req_valid && !busy)  last_rd <= req_read;
  end

  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mdc && !mdio_oe)); // R1
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy); // R1
  AST_MDIO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_oe && $past(mdio_oe) && (mdio_o != $past(mdio_o))) |-> !mdc); // R5
  AST_MDC_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdc) |-> busy); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R9
  AST_ERR_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> last_rd); // R8
  AST_ERR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (rd_data == $past(rd_data))); // R8
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_read  (req_read),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .rd_data   (rd_data),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe)
);

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;
  localparam int HALF = 2;
  localparam logic [4:0] PHY_ADDR = 5'h0B;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_read;
  logic [4:0] req_phy, req_reg;
  logic [15:0] req_wdata;
  logic busy, done, err, mdc, mdio_o, mdio_oe, mdio_i;
  logic [15:0] rd_data;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  mdio_master #(.HALF_PERIOD(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
    .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rd_data(rd_data), .err(err),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // ---------------- PHY model with pull-up on the shared line
  logic phy_oe = 1'b0;
  logic phy_out = 1'b1;
  logic mdio_bus;
  assign mdio_bus = mdio_oe ? mdio_o : (phy_oe ? phy_out : 1'b1);
  assign mdio_i   = mdio_bus;

  int   rises = 0;
  logic bitv [0:127];
  logic oev  [0:127];
  logic [15:0] phy_mem [32];
  logic [15:0] exp_mem [32];
  logic fr_rd = 1'b0, fr_wr = 1'b0, fr_match = 1'b0;
  logic [4:0] fr_reg = '0;

  function automatic logic [15:0] init_val(int r);
    return 16'(r * 16'h0931 + 16'h1C3);
  endfunction

  always @(posedge mdc) begin
    if (rises < 128) begin
      bitv[rises] = mdio_bus;
      oev[rises]  = mdio_oe;
    end
    rises = rises + 1;
    if (rises == 46) begin
      fr_rd    = (bitv[32] == 0) && (bitv[33] == 1) && (bitv[34] == 1) && (bitv[35] == 0);
      fr_wr    = (bitv[32] == 0) && (bitv[33] == 1) && (bitv[34] == 0) && (bitv[35] == 1);
      fr_match = ({bitv[36], bitv[37], bitv[38], bitv[39], bitv[40]} == PHY_ADDR);
      fr_reg   = {bitv[41], bitv[42], bitv[43], bitv[44], bitv[45]};
    end
    if (rises == 64 && fr_wr && fr_match && bitv[46] == 1 && bitv[47] == 0) begin
      logic [15:0] v;
      for (int i = 0; i < 16; i++) v[15-i] = bitv[48+i];
      phy_mem[fr_reg] = v;
    end
  end

  always @(negedge mdc) begin
    if (fr_rd && fr_match && rises == 46) begin
      phy_oe = 1'b1; phy_out = 1'b0;
    end else if (fr_rd && fr_match && rises >= 47 && rises <= 62) begin
      phy_oe = 1'b1; phy_out = phy_mem[fr_reg][62 - rises];
    end else begin
      phy_oe = 1'b0; phy_out = 1'b1;
    end
  end

  // ---------------- timing monitor for R5
  int   viol = 0;
  int   run_len = 0;
  logic prev_mdc = 1'b1, prev_out = 1'b1, prev_oe = 1'b0, rose_seen = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mdc !== prev_mdc) begin
        if (prev_mdc == 1'b0 && run_len != HALF) viol++;
        if (prev_mdc == 1'b1 && rose_seen && run_len != HALF) viol++;
        if (mdc == 1'b1) rose_seen = 1'b1;
        run_len = 1;
      end else begin
        run_len++;
      end
      if (mdio_oe && prev_oe && (mdio_o !== prev_out) && mdc) viol++;
      if (done) rose_seen = 1'b0;
    end
    prev_mdc = mdc; prev_out = mdio_o; prev_oe = mdio_oe;
  end

  // ---------------- checking helpers
  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic exp_bit(int i, bit rd, logic [4:0] pa, logic [4:0] ra, logic [15:0] wd);
    if (i < 32)  return 1'b1;
    if (i == 32) return 1'b0;
    if (i == 33) return 1'b1;
    if (i == 34) return rd;
    if (i == 35) return !rd;
    if (i < 41)  return pa[40 - i];
    if (i < 46)  return ra[45 - i];
    if (i == 46) return 1'b1;
    if (i == 47) return 1'b0;
    return wd[63 - i];
  endfunction

  logic [15:0] last_rd = '0;

  task automatic run_txn(bit rd, logic [4:0] pa, logic [4:0] ra, logic [15:0] wd, bit poke);
    int cyc, exp_rises, b_pre, b_st, b_adr, b_wr, b_oe;
    bit present, miss;
    rises = 0; fr_rd = 0; fr_wr = 0; fr_match = 0; viol = 0;
    @(negedge clk);
    req_valid = 1'b1; req_read = rd; req_phy = pa; req_reg = ra; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy === 1'b1, "R9 busy after accept", 32'(busy), 1);
    if (poke) begin
      repeat (37) @(negedge clk);
      req_valid = 1'b1; req_read = !rd; req_phy = ~pa; req_reg = ~ra; req_wdata = ~wd;
      @(negedge clk);
      req_valid = 1'b0;
    end
    cyc = 0;
    while (done !== 1'b1 && cyc < 4000) begin @(negedge clk); cyc++; end
    chk(done === 1'b1, "R9 done seen", 32'(done), 1);
    present = (pa == PHY_ADDR);
    miss = rd && !present;
    exp_rises = miss ? 79 : 65;
    chk(rises == exp_rises, rd ? (miss ? "R8 rising edges" : "R7 rising edges") : "R6 rising edges",
        32'(rises), 32'(exp_rises));
    b_pre = 0; b_st = 0; b_adr = 0; b_wr = 0; b_oe = 0;
    for (int i = 0; i < exp_rises; i++) begin
      bit eoe;
      eoe = rd ? (i < 46) : (i < 64);
      if (oev[i] !== eoe) b_oe++;
      if (eoe && bitv[i] !== exp_bit(i, rd, pa, ra, wd)) begin
        if (i < 32) b_pre++;
        else if (i < 36) b_st++;
        else if (i < 46) b_adr++;
        else b_wr++;
      end
    end
    chk(b_pre == 0, "R2 preamble bits", 32'(b_pre), 0);
    chk(b_st == 0, "R3 start/opcode bits", 32'(b_st), 0);
    chk(b_adr == 0, "R4 address bits", 32'(b_adr), 0);
    chk(b_oe == 0, rd ? "R7 enable pattern" : "R6 enable pattern", 32'(b_oe), 0);
    if (!rd) chk(b_wr == 0, "R6 turnaround/data bits", 32'(b_wr), 0);
    chk(viol == 0, "R5 phase lengths and change points", 32'(viol), 0);
    if (rd && present) begin
      chk(rd_data === exp_mem[ra], "R7 read data", 32'(rd_data), 32'(exp_mem[ra]));
      chk(err === 1'b0, "R7 no error", 32'(err), 0);
      last_rd = exp_mem[ra];
    end else if (miss) begin
      chk(err === 1'b1, "R8 error flag", 32'(err), 1);
      chk(rd_data === last_rd, "R8 data kept", 32'(rd_data), 32'(last_rd));
    end else begin
      chk(err === 1'b0, "R9 err cleared on write", 32'(err), 0);
      if (present) exp_mem[ra] = wd;
    end
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R9 single pulse", {30'b0, done, busy}, 0);
    chk(mdc === 1'b1 && mdio_oe === 1'b0, "R1 idle lines", {30'b0, mdc, mdio_oe}, 32'h2);
    if (poke) begin
      repeat (20) @(negedge clk);
      chk(busy === 1'b0 && mdc === 1'b1, "R1 ignored request", {30'b0, busy, mdc}, 32'h1);
    end
  endtask

  bit finished = 0;

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R9 watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    for (int r = 0; r < 32; r++) begin
      phy_mem[r] = init_val(r);
      exp_mem[r] = init_val(r);
    end
    rst_n = 1'b0; req_valid = 1'b0; req_read = 1'b0;
    req_phy = '0; req_reg = '0; req_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mdc === 1'b1 && mdio_oe === 1'b0 && busy === 1'b0 && done === 1'b0 && err === 1'b0,
        "R1 reset state", {27'b0, mdc, mdio_oe, busy, done, err}, 32'h10);

    // directed corner cases
    run_txn(1'b1, PHY_ADDR, 5'd3, 16'h0, 1'b0);
    run_txn(1'b0, PHY_ADDR, 5'd31, 16'hFFFF, 1'b0);
    run_txn(1'b1, PHY_ADDR, 5'd31, 16'h0, 1'b0);
    run_txn(1'b0, PHY_ADDR, 5'd0, 16'h0000, 1'b0);
    run_txn(1'b1, PHY_ADDR, 5'd0, 16'h0, 1'b0);
    run_txn(1'b1, 5'h1F, 5'd7, 16'h0, 1'b0);
    run_txn(1'b1, 5'h00, 5'd7, 16'h0, 1'b0);
    run_txn(1'b0, PHY_ADDR, 5'd9, 16'h8001, 1'b1);
    run_txn(1'b1, PHY_ADDR, 5'd9, 16'h0, 1'b1);
    run_txn(1'b1, 5'h14, 5'd9, 16'h0, 1'b0);

    // constrained random mix
    for (int n = 0; n < 36; n++) begin
      logic [4:0] pa;
      pa = ($urandom % 5 == 0) ? 5'(PHY_ADDR ^ (1 + $urandom % 31)) : PHY_ADDR;
      run_txn(1'($urandom % 2), pa, 5'($urandom % 32), 16'($urandom), 1'b0);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule